// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is a free-running up-counter with two output compare channels. The counter steps from zero to a programmable modulo value and then wraps back to zero. Each wrap is an overflow event. When the count equals a channel's compare value, that channel sets, clears or toggles its output pin and raises a compare flag. Flags stay set until software clears them with a write-one-to-clear. An interrupt line is raised whenever an enabled flag is set.

The two channels can be linked into one buffered channel. In that mode the two compare registers take turns owning the output of channel 0. After each compare, ownership passes to the other register, so software can rewrite the idle register without disturbing the edge that is pending. Channel 1's pin then rests at its idle level.

Unlinked channels take a new compare value at once. Such a write can therefore skip a compare, or produce a second compare in the same period.

Register writes and reads go through a plain bus:
- A write is accepted on every cycle that `wr_en` is high. There is no back-pressure and no ready signal.
- A read returns data combinationally for `rd_addr`.

Top module: `tmr_oc_unit`

## Requirements

Register map: address 0 is control, 1 is modulo, 2 is compare A (channel 0), 3 is compare B (channel 1), 4 is flags and 5 is count.

Control bits:
- [0] run
- [1] link
- [2] overflow interrupt enable
- [3] channel 0 interrupt enable
- [4] channel 1 interrupt enable
- [6:5] channel 0 action
- [8:7] channel 1 action

Flag bits: [0] overflow, [1] channel 0 compare, [2] channel 1 compare.

Action codes: 00 none, 01 toggle, 10 clear, 11 set.

- R1: While run is 1, the count rises by one per cycle and goes from the modulo value to 0. While run is 0, the count holds. A write to address 5 loads the count.
- R2: When the count equals a channel's compare value while running, that channel's pin takes the action coded in its action field on the next clock edge. The change is therefore seen while the count shows the compare value plus one.
- R3: A compare match sets that channel's flag. `irq` is 1 exactly when some flag is 1 and its enable bit is 1.
- R4: An unlinked compare write takes effect on the next edge. If the count has already passed the new value in the current period, no match occurs until the count reaches it in the next period.
- R5: A larger compare value written after a match, in the same period, produces a second match in that period.
- R6: With link set, only the channel 0 pin changes, using the channel 0 action. Compare A owns the first match after link is set; each match then hands ownership to the other register.
- R7: With link set, rewriting the register that does not own the output leaves the pending match unchanged. The new value is used when ownership returns to that register.
- R8: With link set, the channel 1 pin is driven to 0 and its action field has no effect.
- R9: When the count passes from the modulo value to 0, the overflow flag is set. Counting that does not wrap leaves it at 0.
- R10: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. A set event in the same cycle wins over the clear.
- R11: Synchronous reset clears the count, all flags, both pins and the control register.
- R12: Reads return the stored register values. The modulo register resets to all ones.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | CNT_W | Read data, combinational |
| tmr_count | output | CNT_W | Current count |
| cmp_pin | output | 2 | Channel output pins, bit 0 is channel 0 |
| irq | output | 1 | Interrupt request |

## Verification

The bench builds the unit with CNT_W set to 10 and programs a modulo of 15. This puts several full counter periods, wraps and overflow flags within a few hundred cycles. The reset value of the modulo register (1023) and compare values above the modulo (which never match) stay easy to read back. With the short period, the bench can place writes at exact count values. It can write just after a match, after the count has passed the new value, and while the idle register is not the owner in linked mode.

// File: rtl/oc_pkg.sv
package oc_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_MOD   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd5;

  typedef enum logic [1:0] {
    ACT_NONE = 2'b00,
    ACT_TOG  = 2'b01,
    ACT_CLR  = 2'b10,
    ACT_SET  = 2'b11
  } act_e;

  typedef struct packed {
    act_e act1;
    act_e act0;
    logic ie1;
    logic ie0;
    logic ovf_ie;
    logic link;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int FLAG_W = 3;
endpackage

// File: rtl/oc_counter.sv
module oc_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] modv,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  assign wrap = run && (cnt == modv);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (run)  cnt <= wrap ? '0 : cnt + 1'b1;
  end

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt == modv) |=> (cnt == '0));
  a_r1_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(cnt));
endmodule

// File: rtl/oc_link.sv
module oc_link #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             link,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [1:0]       fire,
  output logic [1:0]       hit
);
  logic owner;
  logic eq_a, eq_b, own_eq;

  assign eq_a   = run && (cnt == cmp_a);
  assign eq_b   = run && (cnt == cmp_b);
  assign own_eq = owner ? eq_b : eq_a;

  always_comb begin
    if (link) begin
      fire = {1'b0, own_eq};
      hit  = owner ? {own_eq, 1'b0} : {1'b0, own_eq};
    end else begin
      fire = {eq_b, eq_a};
      hit  = {eq_b, eq_a};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !link) owner <= 1'b0;
    else if (own_eq)  owner <= ~owner;
  end

  a_r6_handover: assert property (@(posedge clk) disable iff (rst)
    (link && (hit != 2'b00)) |=> (owner != $past(owner)));
  a_r6_one_owner: assert property (@(posedge clk) disable iff (rst)
    link |-> $onehot0(hit));
  a_r7_idle_keeps_owner: assert property (@(posedge clk) disable iff (rst)
    (link && hit == 2'b00) |=> $stable(owner));
endmodule

// File: rtl/oc_channel.sv
module oc_channel
  import oc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic fire,
  input  act_e act,
  input  logic force_idle,
  output logic pin
);
  always_ff @(posedge clk) begin
    if (rst || force_idle) pin <= 1'b0;
    else if (fire) begin
      case (act)
        ACT_TOG: pin <= ~pin;
        ACT_CLR: pin <= 1'b0;
        ACT_SET: pin <= 1'b1;
        default: pin <= pin;
      endcase
    end
  end

  a_r2_set: assert property (@(posedge clk) disable iff (rst)
    (fire && act == ACT_SET && !force_idle) |=> pin);
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    (fire && act == ACT_CLR) |=> !pin);
  a_r2_toggle: assert property (@(posedge clk) disable iff (rst)
    (fire && act == ACT_TOG && !force_idle) |=> (pin != $past(pin)));
  a_r2_quiet: assert property (@(posedge clk) disable iff (rst)
    (!fire && !force_idle) |=> $stable(pin));
  a_r8_idle_low: assert property (@(posedge clk) disable iff (rst)
    force_idle |=> !pin);
endmodule

// File: rtl/tmr_oc_unit.sv
module tmr_oc_unit
  import oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  output logic [CNT_W-1:0]  tmr_count,
  output logic [1:0]        cmp_pin,
  output logic              irq
);
  localparam int NCH = 2;

  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] cmp_q [NCH];
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] set_vec, clr_vec, ie_vec;
  logic [1:0]       fire, hit;
  logic             wrap;
  logic             cnt_load;
  act_e             act_v [NCH];
  logic             idle_v [NCH];

  assign cnt_load = wr_en && (wr_addr == A_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mod_q  <= '1;
      cmp_q[0] <= '0;
      cmp_q[1] <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: ctrl_q   <= ctrl_t'(wr_data[CTRL_W-1:0]);
        A_MOD:  mod_q    <= wr_data;
        A_CMPA: cmp_q[0] <= wr_data;
        A_CMPB: cmp_q[1] <= wr_data;
        default: ;
      endcase
    end
  end

  oc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .load(cnt_load),
    .load_val(wr_data), .modv(mod_q), .cnt(tmr_count), .wrap(wrap)
  );

  oc_link #(.CNT_W(CNT_W)) u_link (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .link(ctrl_q.link),
    .cnt(tmr_count), .cmp_a(cmp_q[0]), .cmp_b(cmp_q[1]),
    .fire(fire), .hit(hit)
  );

  assign act_v[0]  = ctrl_q.act0;
  assign act_v[1]  = ctrl_q.act1;
  assign idle_v[0] = 1'b0;
  assign idle_v[1] = ctrl_q.link;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    oc_channel u_ch (
      .clk(clk), .rst(rst), .fire(fire[g]), .act(act_v[g]),
      .force_idle(idle_v[g]), .pin(cmp_pin[g])
    );
  end

  assign set_vec = {hit, wrap};
  assign clr_vec = (wr_en && wr_addr == A_FLAGS) ? wr_data[FLAG_W-1:0] : '0;
  assign ie_vec  = {ctrl_q.ie1, ctrl_q.ie0, ctrl_q.ovf_ie};

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= (flags_q & ~clr_vec) | set_vec;
  end

  assign irq = |(flags_q & ie_vec);

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = CNT_W'(ctrl_q);
      A_MOD:   rd_data = mod_q;
      A_CMPA:  rd_data = cmp_q[0];
      A_CMPB:  rd_data = cmp_q[1];
      A_FLAGS: rd_data = CNT_W'(flags_q);
      A_COUNT: rd_data = tmr_count;
      default: rd_data = '0;
    endcase
  end

  a_r9_ovf_flag: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q.run && !cnt_load && tmr_count == mod_q) |=> flags_q[0]);
  a_r3_cmp_flag: assert property (@(posedge clk) disable iff (rst)
    hit[0] |=> flags_q[1]);
  a_r10_w1c: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_FLAGS && wr_data[1] && !hit[0]) |=> !flags_q[1]);
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    (flags_q[2] && !(wr_en && wr_addr == A_FLAGS && wr_data[2])) |=> flags_q[2]);
endmodule

// File: tb/tmr_oc_unit_tb.sv
module tmr_oc_unit_tb;
  localparam int W = 10;

  typedef struct {
    logic [1:0]   pins;
    logic [W-1:0] cnt;
    string        tag;
  } ev_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] rd_data;
  logic [W-1:0] tmr_count;
  logic [1:0]   cmp_pin;
  logic         irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;
  bit  mon_en = 0;
  ev_t q[$];
  logic [1:0] prev_pins = 2'b00;

  tmr_oc_unit #(.CNT_W(W)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tmr_count(tmr_count),
    .cmp_pin(cmp_pin), .irq(irq)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] mk(bit run, bit link, bit ovie, bit ie0,
                                       bit ie1, logic [1:0] a0, logic [1:0] a1);
    return W'({a1, a0, ie1, ie0, ovie, link, run});
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic chk_rd(logic [2:0] a, logic [W-1:0] exp, string tag);
    rd_addr = a;
    #1;
    check(tag, 32'(rd_data), 32'(exp));
  endtask

  task automatic wait_count(logic [W-1:0] v);
    while (tmr_count != v) @(negedge clk);
  endtask

  task automatic push(logic [1:0] p, logic [W-1:0] c, string tag);
    ev_t e;
    e.pins = p; e.cnt = c; e.tag = tag;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (rst || !mon_en) prev_pins = cmp_pin;
    else if (cmp_pin !== prev_pins) begin
      if (q.size() == 0) begin
        check("unexpected pin change", 32'(cmp_pin), 32'(prev_pins));
      end else begin
        ev_t e;
        e = q.pop_front();
        check({e.tag, " pins"}, 32'(cmp_pin), 32'(e.pins));
        check({e.tag, " count"}, 32'(tmr_count), 32'(e.cnt));
      end
      prev_pins = cmp_pin;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 / R12 reset state
    check("R11 pins", 32'(cmp_pin), 0);
    check("R11 irq", 32'(irq), 0);
    chk_rd(3'd5, 0, "R11 count");
    chk_rd(3'd4, 0, "R11 flags");
    chk_rd(3'd1, 10'h3FF, "R12 modulo reset");
    wr(3'd1, 15);
    chk_rd(3'd1, 15, "R12 modulo readback");
    wr(3'd2, 3);
    wr(3'd3, 7);
    mon_en = 1;

    // R1 R2: toggle on ch0, set on ch1, two periods
    push(2'b01, 4, "R2 toggle");
    push(2'b11, 8, "R2 set");
    push(2'b10, 4, "R2 toggle again");
    wr(3'd0, mk(1, 0, 0, 0, 0, 2'b01, 2'b11));
    wait_count(15);
    wait_count(6);
    wr(3'd0, mk(0, 0, 0, 0, 0, 2'b01, 2'b11));
    repeat (3) @(negedge clk);
    chk_rd(3'd5, 7, "R1 hold when stopped");
    chk_rd(3'd4, 7, "R3 R9 flags after run");
    check("R3 irq disabled", 32'(irq), 0);
    wr(3'd0, mk(0, 0, 0, 1, 0, 2'b01, 2'b11));
    check("R3 irq ch0 enabled", 32'(irq), 1);
    wr(3'd4, 3'b010);
    chk_rd(3'd4, 5, "R10 clear one flag");
    check("R10 irq after clear", 32'(irq), 0);
    wr(3'd4, 0);
    chk_rd(3'd4, 5, "R10 zero write keeps");
    wr(3'd0, mk(0, 0, 1, 1, 0, 2'b01, 2'b11));
    check("R3 irq overflow enabled", 32'(irq), 1);
    wr(3'd4, 3'b111);
    check("R10 irq all cleared", 32'(irq), 0);

    // R4: write a value already passed
    wr(3'd5, 0);
    chk_rd(3'd5, 0, "R1 count load");
    wr(3'd2, 14);
    wr(3'd3, 1000);
    wr(3'd0, mk(1, 0, 0, 0, 0, 2'b00, 2'b00));
    wait_count(8);
    wr(3'd2, 5);
    wait_count(0);
    chk_rd(3'd4, 1, "R4 no match after passed write");
    wait_count(7);
    chk_rd(3'd4, 3, "R4 match next period");
    wr(3'd0, mk(0, 0, 0, 0, 0, 2'b00, 2'b00));
    wr(3'd4, 3'b111);

    // R5: second compare in one period
    wr(3'd5, 0);
    wr(3'd2, 3);
    push(2'b11, 4, "R5 first compare");
    push(2'b10, 10, "R5 second compare");
    wr(3'd0, mk(1, 0, 0, 0, 0, 2'b01, 2'b00));
    wait_count(4);
    wr(3'd2, 9);
    wait_count(11);
    wr(3'd0, mk(0, 0, 0, 0, 0, 2'b01, 2'b00));
    chk_rd(3'd4, 2, "R5 R9 compare flag only, no wrap");
    wr(3'd4, 3'b111);

    // R6 R7 R8: linked buffered channel
    wr(3'd5, 0);
    wr(3'd2, 3);
    wr(3'd3, 8);
    push(2'b00, 0, "R8 ch1 idle on link");
    wr(3'd0, mk(0, 1, 0, 0, 0, 2'b01, 2'b11));
    @(negedge clk);
    push(2'b01, 4, "R6 reg A owns first");
    push(2'b00, 9, "R6 reg B next");
    push(2'b01, 4, "R6 back to reg A");
    push(2'b00, 9, "R7 pending reg B unaffected");
    push(2'b01, 13, "R7 rewritten reg A used");
    wr(3'd0, mk(1, 1, 0, 0, 0, 2'b01, 2'b11));
    wait_count(15);
    wait_count(5);
    wr(3'd2, 12);
    wait_count(14);
    wr(3'd0, mk(0, 1, 0, 0, 0, 2'b01, 2'b11));
    repeat (2) @(negedge clk);
    check("R8 ch1 pin low", 32'(cmp_pin[1]), 0);
    chk_rd(3'd4, 7, "R6 both compare flags");
    check("R6 R7 events consumed", 32'(q.size()), 0);

    // R11: reset while running
    wr(3'd0, mk(1, 0, 0, 1, 0, 2'b11, 2'b11));
    repeat (5) @(negedge clk);
    mon_en = 0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 pins after reset", 32'(cmp_pin), 0);
    check("R11 irq after reset", 32'(irq), 0);
    chk_rd(3'd4, 0, "R11 flags after reset");
    chk_rd(3'd0, 0, "R11 control after reset");
    chk_rd(3'd5, 0, "R11 count after reset");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule